// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds a bank of programmable event counters. Every counter has its own event-select register. That register picks one line from a vector of single-cycle event strobes, and it gates counting with an enable bit. Software reaches the bank through a plain register port: a numeric address, a one-cycle write of 32 bits and a registered read of 64 bits.

A read-only capability word at a fixed address gives the version, the number of counter/select pairs and the counter width, so software can size the bank before it programs it. Counter writes can only set the low 32 bits of a counter. Counter reads return the whole implemented width.

Top module: `perfctr_bank`

## Requirements
- R1: The capability register at address 0x0C0 reads the version (default 1) in bits 7:0, the number of pairs in bits 15:8 and the counter width in bits 23:16. All other bits read zero. Writes to it are ignored.
- R2: Counter i sits at address 0x0C1+i and select register i at 0x186+i. Select register i controls only counter i.
- R3: A select register stores the event code from write bits 7:0 and the enable from write bit 22. Every other bit reads back as zero.
- R4: A counter adds one on each clock where its select is enabled and the event line numbered by its code is high. A disabled select never counts. A code at or above the number of event lines never counts.
- R5: A counter write replaces counter bits 31:0 with the write data. Counter bits from 32 up to the width keep their value. Write bits at or above the counter width are dropped.
- R6: A counter read returns the full counter width, zero-extended to 64 bits.
- R7: A counter holding its all-ones value goes to zero on its next increment.
- R8: A read of an unmapped address returns zero. A write to an unmapped address changes no register.
- R9: When a counter is written in a cycle where it would also increment, it takes the written value and the increment is lost.
- R10: Read data is captured at the clock edge that accepts rd_en. It reflects register state from before any write in that same cycle. It holds its value while rd_en is low.
- R11: Synchronous reset clears every counter, every select register and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_EVT | Event strobes, one per event code |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 64 | Registered read data |

## Verification
- **Read results:** a read result is due on the rising edge that samples rd_en. The bench compares rdata at the following falling edge.
- **Event counts:** an event strobe or a write changes a counter at the edge that samples it. A read in that same cycle still returns the older value, and only a read issued one cycle later shows the change.
- **Reference model:** the behavioural model in the bench advances on each rising edge from the same sampled inputs. It produces the expected read word for that edge, so every falling-edge comparison lines up with the cycle in which the design changes.
- **Wrap case:** a second instance with 16-bit counters makes the wrap to zero reachable in a short run.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;

    localparam int ADDR_W  = 12;
    localparam int WDATA_W = 32;
    localparam int RDATA_W = 64;
    localparam int CODE_W  = 8;
    localparam int EN_BIT  = 22;

    localparam logic [ADDR_W-1:0] CAP_ADDR = 12'h0C0;
    localparam logic [ADDR_W-1:0] CTR_BASE = 12'h0C1;
    localparam logic [ADDR_W-1:0] SEL_BASE = 12'h186;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_CAP,
        RK_CTR,
        RK_SEL
    } regkind_t;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } evsel_t;

    function automatic logic [RDATA_W-1:0] sel_to_word(input evsel_t s);
        logic [RDATA_W-1:0] w;
        w             = '0;
        w[CODE_W-1:0] = s.code;
        w[EN_BIT]     = s.en;
        return w;
    endfunction

    function automatic logic [RDATA_W-1:0] cap_word(input int ver, input int pairs, input int width);
        logic [RDATA_W-1:0] w;
        w        = '0;
        w[7:0]   = 8'(ver);
        w[15:8]  = 8'(pairs);
        w[23:16] = 8'(width);
        return w;
    endfunction

endpackage

// File: rtl/perfctr_evsel.sv
module perfctr_evsel
    import perfctr_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CODE_W-1:0] code_in,
    input  logic              en_in,
    input  logic [NUM_EVT-1:0] evt,
    output evsel_t            sel_q,
    output logic              hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr) begin
            sel_q.code <= code_in;
            sel_q.en   <= en_in;
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < NUM_EVT; j++) begin
            if (sel_q.code == CODE_W'(j)) hit = evt[j];
        end
        hit = hit & sel_q.en;
    end

    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (sel_q.code == $past(code_in)) && (sel_q.en == $past(en_in)));

    // R11
    sel_reset_chk: assert property (@(posedge clk)
        rst |=> (sel_q == '0));

endmodule

// File: rtl/perfctr_counter.sv
module perfctr_counter #(
    parameter int CTR_W = 40,
    localparam int LOW_W = (CTR_W > 32) ? 32 : CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [LOW_W-1:0] wdat,
    input  logic             hit,
    output logic [CTR_W-1:0] cnt
);

    logic [CTR_W-1:0] wval;

    generate
        if (CTR_W > 32) begin : g_keep_high
            assign wval = {cnt[CTR_W-1:32], wdat};
        end else begin : g_full
            assign wval = wdat;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= wval;
        end else if (hit) begin
            cnt <= cnt + CTR_W'(1);
        end
    end

    // R4 / R7
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !wr) |=> (cnt == $past(cnt) + CTR_W'(1)));

    // R9
    wr_win_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt[LOW_W-1:0] == $past(wdat)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && !wr) |=> $stable(cnt));

endmodule

// File: rtl/perfctr_regif.sv
module perfctr_regif
    import perfctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 40,
    parameter int VERSION = 1,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]   ctr_q,
    input  evsel_t [NUM_CTR-1:0]            sel_q,
    output logic [NUM_CTR-1:0]              ctr_wr,
    output logic [NUM_CTR-1:0]              sel_wr,
    output logic [RDATA_W-1:0]              rdata
);

    regkind_t          kind;
    logic [IDX_W-1:0]  idx;
    logic [RDATA_W-1:0] rd_mux;

    always_comb begin
        kind = RK_NONE;
        idx  = '0;
        if (addr == CAP_ADDR) begin
            kind = RK_CAP;
        end else if (32'(addr) >= 32'(CTR_BASE) &&
                     32'(addr) <  32'(CTR_BASE) + 32'(NUM_CTR)) begin
            kind = RK_CTR;
            idx  = IDX_W'(addr - CTR_BASE);
        end else if (32'(addr) >= 32'(SEL_BASE) &&
                     32'(addr) <  32'(SEL_BASE) + 32'(NUM_CTR)) begin
            kind = RK_SEL;
            idx  = IDX_W'(addr - SEL_BASE);
        end
    end

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
            assign ctr_wr[i] = wr_en && (kind == RK_CTR) && (idx == IDX_W'(i));
            assign sel_wr[i] = wr_en && (kind == RK_SEL) && (idx == IDX_W'(i));
        end
    endgenerate

    always_comb begin
        case (kind)
            RK_CAP:  rd_mux = cap_word(VERSION, NUM_CTR, CTR_W);
            RK_CTR:  rd_mux = RDATA_W'(ctr_q[idx]);
            RK_SEL:  rd_mux = sel_to_word(sel_q[idx]);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && kind == RK_NONE) |=> (rdata == '0));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctr_wr, sel_wr}));

    // R11
    rd_reset_chk: assert property (@(posedge clk)
        rst |=> (rdata == '0));

endmodule

// File: rtl/perfctr_bank.sv
module perfctr_bank
    import perfctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 40,
    parameter int NUM_EVT = 8,
    parameter int VERSION = 1,
    localparam int LOW_W  = (CTR_W > 32) ? 32 : CTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [11:0]        addr,
    input  logic [31:0]        wdata,
    output logic [63:0]        rdata
);

    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
    evsel_t [NUM_CTR-1:0]          sel_q;
    logic [NUM_CTR-1:0]            ctr_wr;
    logic [NUM_CTR-1:0]            sel_wr;
    logic [NUM_CTR-1:0]            hit;

    perfctr_regif #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .VERSION (VERSION)
    ) u_regif (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .ctr_q  (ctr_q),
        .sel_q  (sel_q),
        .ctr_wr (ctr_wr),
        .sel_wr (sel_wr),
        .rdata  (rdata)
    );

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_pair
            perfctr_evsel #(
                .NUM_EVT (NUM_EVT)
            ) u_sel (
                .clk     (clk),
                .rst     (rst),
                .wr      (sel_wr[i]),
                .code_in (wdata[CODE_W-1:0]),
                .en_in   (wdata[EN_BIT]),
                .evt     (evt),
                .sel_q   (sel_q[i]),
                .hit     (hit[i])
            );

            perfctr_counter #(
                .CTR_W (CTR_W)
            ) u_ctr (
                .clk  (clk),
                .rst  (rst),
                .wr   (ctr_wr[i]),
                .wdat (wdata[LOW_W-1:0]),
                .hit  (hit[i]),
                .cnt  (ctr_q[i])
            );
        end
    endgenerate

endmodule

// File: tb/perfctr_bank_test.sv
module perfctr_bank_test;

    localparam int NCTR = 4;
    localparam int NEVT = 8;
    localparam int WBIG = 40;
    localparam int WSML = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NEVT-1:0] evt = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [63:0] rdata_big;
    logic [63:0] rdata_sml;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string phase = "R11 reset";

    always #2 clk = ~clk;

    perfctr_bank #(.NUM_CTR(NCTR), .CTR_W(WBIG), .NUM_EVT(NEVT)) uut (
        .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_big));

    perfctr_bank #(.NUM_CTR(NCTR), .CTR_W(WSML), .NUM_EVT(NEVT)) uut_w16 (
        .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_sml));

    // Behavioural reference: index 0 = 40-bit instance, 1 = 16-bit instance
    logic [63:0] ctr_m [2][NCTR];
    logic [63:0] sel_m [2][NCTR];
    logic [63:0] rd_m  [2];
    string       kind_m = "R11";

    function automatic logic [63:0] wmask(input int k);
        return (k == 0) ? ((64'd1 << WBIG) - 1) : ((64'd1 << WSML) - 1);
    endfunction

    function automatic logic [63:0] mread(input int k, input int a);
        int w;
        w = (k == 0) ? WBIG : WSML;
        if (a == 'h0C0) return 64'(1) | (64'(NCTR) << 8) | (64'(w) << 16);
        for (int i = 0; i < NCTR; i++) begin
            if (a == 'h0C1 + i) return ctr_m[k][i];
            if (a == 'h186 + i) return sel_m[k][i];
        end
        return 64'd0;
    endfunction

    function automatic string kind_of(input int a);
        if (a == 'h0C0) return "R1";
        if (a >= 'h0C1 && a < 'h0C1 + NCTR) return "R6";
        if (a >= 'h186 && a < 'h186 + NCTR) return "R3";
        return "R8";
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                rd_m[k] = '0;
                for (int i = 0; i < NCTR; i++) begin
                    ctr_m[k][i] = '0;
                    sel_m[k][i] = '0;
                end
            end else begin
                if (rd_en) rd_m[k] = mread(k, int'(addr));
                for (int i = 0; i < NCTR; i++) begin
                    int  code;
                    bit  h;
                    code = int'(sel_m[k][i][7:0]);
                    h = sel_m[k][i][22] && (code < NEVT) && evt[code % NEVT];
                    if (wr_en && int'(addr) == 'h0C1 + i)
                        ctr_m[k][i] = ((ctr_m[k][i] & ~64'hFFFF_FFFF) | 64'(wdata)) & wmask(k);
                    else if (h)
                        ctr_m[k][i] = (ctr_m[k][i] + 1) & wmask(k);
                    if (wr_en && int'(addr) == 'h186 + i)
                        sel_m[k][i] = 64'(wdata) & 64'h0040_00FF;
                end
            end
        end
        if (rd_en && !rst) kind_m = kind_of(int'(addr));
    end

    task automatic compare();
        checks++;
        if (rdata_big !== rd_m[0]) begin
            fails++;
            $display("FAIL %s/%s w40: rdata=%h expected=%h", phase, kind_m, rdata_big, rd_m[0]);
        end
        checks++;
        if (rdata_sml !== rd_m[1]) begin
            fails++;
            $display("FAIL %s/%s w16: rdata=%h expected=%h", phase, kind_m, rdata_sml, rd_m[1]);
        end
    endtask

    task automatic step(input bit w, input bit r, input int a, input logic [31:0] d,
                        input logic [NEVT-1:0] e);
        @(negedge clk);
        compare();
        wr_en = w; rd_en = r; addr = 12'(a); wdata = d; evt = e;
    endtask

    task automatic rd(input int a);
        step(0, 1, a, 32'h0, '0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step(1, 0, a, d, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) step(0, 1, 'h0C0, 32'h0, '1);   // R11: reads stay zero in reset
        rst = 1'b0;

        phase = "R1 capability";
        rd('h0C0);
        wr('h0C0, 32'hFFFF_FFFF);
        rd('h0C0);

        phase = "R3 select fields";
        wr('h186, 32'hA5A5_0002 | 32'h0040_0000);  // ctr0: event 2, enabled
        wr('h187, 32'h0040_0005);                  // ctr1: event 5, enabled
        wr('h188, 32'h0040_0040);                  // ctr2: unsupported code
        wr('h189, 32'h0000_0001);                  // ctr3: disabled
        for (int i = 0; i < NCTR; i++) rd('h186 + i);

        phase = "R4 counting";
        for (int c = 0; c < 300; c++)
            step(0, (c % 3) == 0, 'h0C1 + (c % NCTR), 32'h0, NEVT'($urandom));
        for (int i = 0; i < NCTR; i++) rd('h0C1 + i);

        phase = "R9 write beats increment";
        step(1, 0, 'h0C1, 32'h1234_5678, 8'h04);
        rd('h0C1);

        phase = "R6 carry above 32";
        wr('h0C1, 32'hFFFF_FFFE);
        repeat (3) step(0, 0, 'h0, 32'h0, 8'h04);
        rd('h0C1);
        phase = "R5 upper bits kept";
        wr('h0C1, 32'h0000_0000);
        rd('h0C1);

        phase = "R7 wrap";
        wr('h0C2, 32'hABCD_FFFE);
        repeat (3) step(0, 0, 'h0, 32'h0, 8'h20);
        rd('h0C2);

        phase = "R8 unmapped";
        wr('h0C5, 32'hDEAD_BEEF);
        wr('h18A, 32'h0040_0001);
        wr('h000, 32'h1);
        rd('h0C5);
        rd('h18A);
        rd('h000);
        for (int i = 0; i < NCTR; i++) begin
            rd('h0C1 + i);
            rd('h186 + i);
        end

        phase = "R10 read during write";
        step(1, 1, 'h0C4, 32'h0000_0077, '0);
        rd('h0C4);
        repeat (4) step(0, 0, 'h0C4, 32'h0, '0);

        phase = "R2 mixed";
        for (int c = 0; c < 3000; c++) begin
            int a;
            case ($urandom % 4)
                0: a = 'h0C1 + int'($urandom % NCTR);
                1: a = 'h186 + int'($urandom % NCTR);
                2: a = 'h0C0;
                default: a = int'($urandom % 'h200);
            endcase
            step(($urandom % 6) == 0, ($urandom % 2) == 0, a,
                 32'($urandom) & 32'h0040_FF07 | (($urandom % 2) ? 32'h0040_0000 : 32'h0),
                 NEVT'($urandom));
        end
        rd('h0C1);
        step(0, 0, 'h0, 32'h0, '0);
        compare();
        finish_run();
    end

endmodule